// File: doc/BRIEF.md
# Multibank row-register DRAM cache

This block is a behavioural, synthesizable model of a DRAM device with an SRAM row cache in front of it. The array is cut into `NSEG` segments, and each segment owns one register that holds a complete row and a tag latch that remembers which row of the segment that register holds. A read never reaches the array directly. It compares the requested row against the tag of its segment, reports the result on an active-low hit flag, and returns the word from the segment's register. On a mismatch, a single wide transfer reloads the whole row first, so the miss takes longer than a hit.

Writes go into a one-entry posting register and are accepted in the cycle they are presented. On the following edge the posted word is committed to the array. If its row is the one held by its segment's register, the register word is updated at the same time, which keeps the cache coherent. A free-running refresh counter steps through the array rows. Each refresh step waits until no row fill and no posted-write commit is taking place in that cycle.

Requests use a plain strobe: `req_i` together with `we_i`, a row address and a column address, qualified by `ready_o`. The top bits of the row address select the segment, and the low bits select the row inside that segment.

Top module: `cdram_cache`

## Requirements
- R1: After reset, `ready_o`=1, `rvalid_o`=0, `hit_no`=1 and `rdata_o`=0, and no segment holds a row. The first read into each segment is therefore a miss, and the array reads as all zeros.
- R2: A read is accepted on a rising edge where `req_i`=1, `we_i`=0 and `ready_o`=1. On a hit, `rvalid_o` is high for exactly one cycle, starting HIT_LAT (default 2) edges after the accepting edge. `ready_o` is low from the accepting edge until that cycle and is high again while `rvalid_o` is high.
- R3: On a read miss, `rvalid_o` rises MISS_LAT (default 5) edges after the accepting edge, with the same handshake as R2.
- R4: On every accepted request (read or write), `hit_no` is updated at the accepting edge. It becomes 0 when the addressed segment holds a row whose index equals `row_i[RIW-1:0]`, and 1 otherwise. It holds its value until the next accepted request.
- R5: A read miss loads the entire addressed row into the segment register. Later reads of any column of that row, in any order, are hits, and every read returns the current array contents of the addressed word.
- R6: The segment is `row_i[RAW-1 -: SW]`. Each segment keeps its own cached row, so a miss in one segment does not evict the rows held by the others.
- R7: A write (`we_i`=1) is accepted when `ready_o`=1, and `ready_o` stays high on the next cycle. A read accepted on the very next edge returns the written data.
- R8: A write to the row held by its segment updates the register word, and a later read of that word hits and returns the new data. A write to any other row reaches the array and is returned by the next miss on that row.
- R9: When idle, `refresh_o` pulses for one cycle every REF_PERIOD cycles. `refresh_row_o` advances by one, modulo the total row count, after each pulse.
- R10: `refresh_o` is never high in a cycle that performs a row fill or a posted-write commit, and refresh never changes stored data.
- R11: A request presented while `ready_o`=0 is ignored: it writes nothing and does not alter `hit_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| row_i | input | RAW | row address, segment in the top SW bits |
| col_i | input | CAW | column address |
| wdata_i | input | DW | write data |
| ready_o | output | 1 | a request can be accepted |
| rvalid_o | output | 1 | read data valid, one cycle |
| rdata_o | output | DW | read data |
| hit_no | output | 1 | row-compare result, low on hit |
| refresh_o | output | 1 | refresh step taken this cycle |
| refresh_row_o | output | RAW | next row to refresh |

## Verification
The bench builds the block with 16-bit words, four segments of four rows and eight columns, and a refresh period of 16 cycles, while keeping the default latencies of 2 and 5. The array then has only 16 rows, so the bench can write the whole array, hit every segment, force same-segment evictions, and watch the refresh row counter wrap within a short run. The short refresh period also makes refresh requests land inside fills and write commits during a mixed stress sequence.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_HIT, RD_MISS} rd_kind_e;
endpackage

// File: rtl/cdram_array.sv
module cdram_array #(
  parameter int DW   = 72,
  parameter int RAW  = 5,
  parameter int COLS = 16,
  parameter int CAW  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [RAW-1:0]            wr_row_i,
  input  logic [CAW-1:0]            wr_col_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [RAW-1:0]            rd_row_i,
  output logic [COLS-1:0][DW-1:0]   rd_line_o
);
  localparam int NROWS = 1 << RAW;

  logic [COLS-1:0][DW-1:0] mem_q [NROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NROWS; r++) mem_q[r] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_row_i][wr_col_i] <= wr_data_i;
    end
  end

  // whole-row read port feeding the fill bus
  assign rd_line_o = mem_q[rd_row_i];
endmodule

// File: rtl/cdram_segreg.sv
module cdram_segreg #(
  parameter int DW     = 72,
  parameter int COLS   = 16,
  parameter int CAW    = 4,
  parameter int RIW    = 3,
  parameter int SW     = 2,
  parameter int SEG_ID = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fill_i,
  input  logic [RIW-1:0]          fill_tag_i,
  input  logic [COLS-1:0][DW-1:0] fill_line_i,
  input  logic                    wr_en_i,
  input  logic [SW-1:0]           wr_seg_i,
  input  logic [RIW-1:0]          wr_tag_i,
  input  logic [CAW-1:0]          wr_col_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic                    valid_o,
  output logic [RIW-1:0]          tag_o,
  output logic [COLS-1:0][DW-1:0] line_o
);
  logic                    valid_q;
  logic [RIW-1:0]          tag_q;
  logic [COLS-1:0][DW-1:0] line_q;
  logic                    wr_hit;

  // coherence comparator on the commit path
  assign wr_hit = wr_en_i && valid_q && (wr_seg_i == SW'(SEG_ID)) && (wr_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag_i;
      line_q  <= fill_line_i;
    end else if (wr_hit) begin
      line_q[wr_col_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign line_o  = line_q;
endmodule

// File: rtl/cdram_refresh.sv
module cdram_refresh #(
  parameter int RAW    = 5,
  parameter int PERIOD = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           block_i,
  output logic           refresh_o,
  output logic [RAW-1:0] row_o
);
  localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

  logic [CW-1:0]  cnt_q;
  logic           pend_q;
  logic [RAW-1:0] row_q;
  logic           wrap;

  assign wrap      = (cnt_q == CW'(PERIOD - 1));
  assign refresh_o = pend_q && !block_i;
  assign row_o     = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)           pend_q <= 1'b1;
      else if (refresh_o) pend_q <= 1'b0;
      if (refresh_o)      row_q  <= row_q + 1'b1;
    end
  end
endmodule

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
  import cdram_pkg::*;
#(
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_acc_i,
  input  logic wr_acc_i,
  input  logic hit_i,
  output logic busy_o,
  output logic fill_o,
  output logic cap_o,
  output logic hit_no,
  output logic rvalid_o
);
  localparam int LW = $clog2(MISS_LAT + 1);

  rd_kind_e      kind_q;
  logic [LW-1:0] cnt_q;
  logic          hit_nq;
  logic          rvalid_q;

  assign busy_o   = (kind_q != RD_NONE);
  // fill one edge before the capture so the register is current
  assign fill_o   = (kind_q == RD_MISS) && (cnt_q == LW'(1));
  assign cap_o    = busy_o && (cnt_q == '0);
  assign hit_no   = hit_nq;
  assign rvalid_o = rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= RD_NONE;
      cnt_q    <= '0;
      hit_nq   <= 1'b1;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_o;
      if (rd_acc_i) begin
        kind_q <= hit_i ? RD_HIT : RD_MISS;
        cnt_q  <= hit_i ? LW'(HIT_LAT - 1) : LW'(MISS_LAT - 1);
      end else if (cap_o) begin
        kind_q <= RD_NONE;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (rd_acc_i || wr_acc_i) hit_nq <= !hit_i;
    end
  end
endmodule

// File: rtl/cdram_cache.sv
module cdram_cache #(
  parameter int DW           = 72,
  parameter int NSEG         = 4,
  parameter int ROWS_PER_SEG = 8,
  parameter int COLS         = 16,
  parameter int HIT_LAT      = 2,
  parameter int MISS_LAT     = 5,
  parameter int REF_PERIOD   = 64,
  localparam int SW  = $clog2(NSEG),
  localparam int RIW = $clog2(ROWS_PER_SEG),
  localparam int RAW = SW + RIW,
  localparam int CAW = $clog2(COLS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [RAW-1:0] row_i,
  input  logic [CAW-1:0] col_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           ready_o,
  output logic           rvalid_o,
  output logic [DW-1:0]  rdata_o,
  output logic           hit_no,
  output logic           refresh_o,
  output logic [RAW-1:0] refresh_row_o
);
  logic                    busy, fill, cap, rd_acc, wr_acc, sel_hit;
  logic [SW-1:0]           seg_in, seg_q;
  logic [RIW-1:0]          tag_in, tag_q;
  logic [CAW-1:0]          col_q;
  logic [NSEG-1:0]         seg_valid;
  logic [RIW-1:0]          seg_tag  [NSEG];
  logic [COLS-1:0][DW-1:0] seg_line [NSEG];
  logic [COLS-1:0][DW-1:0] arr_line;
  logic                    post_v;
  logic [RAW-1:0]          post_row;
  logic [CAW-1:0]          post_col;
  logic [DW-1:0]           post_data;
  logic [DW-1:0]           rdata_q;

  assign ready_o = !busy;
  assign rd_acc  = req_i && ready_o && !we_i;
  assign wr_acc  = req_i && ready_o && we_i;
  assign seg_in  = row_i[RAW-1 -: SW];
  assign tag_in  = row_i[RIW-1:0];
  assign sel_hit = seg_valid[seg_in] && (seg_tag[seg_in] == tag_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q     <= '0;
      tag_q     <= '0;
      col_q     <= '0;
      post_v    <= 1'b0;
      post_row  <= '0;
      post_col  <= '0;
      post_data <= '0;
      rdata_q   <= '0;
    end else begin
      if (rd_acc) begin
        seg_q <= seg_in;
        tag_q <= tag_in;
        col_q <= col_i;
      end
      // posting register: drains on the edge after acceptance
      post_v <= wr_acc;
      if (wr_acc) begin
        post_row  <= row_i;
        post_col  <= col_i;
        post_data <= wdata_i;
      end
      if (cap) rdata_q <= seg_line[seg_q][col_q];
    end
  end

  assign rdata_o = rdata_q;

  cdram_ctrl #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_acc_i(rd_acc), .wr_acc_i(wr_acc),
    .hit_i(sel_hit), .busy_o(busy), .fill_o(fill), .cap_o(cap),
    .hit_no(hit_no), .rvalid_o(rvalid_o)
  );

  cdram_array #(.DW(DW), .RAW(RAW), .COLS(COLS), .CAW(CAW)) array_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(post_v), .wr_row_i(post_row),
    .wr_col_i(post_col), .wr_data_i(post_data), .rd_row_i({seg_q, tag_q}),
    .rd_line_o(arr_line)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    cdram_segreg #(
      .DW(DW), .COLS(COLS), .CAW(CAW), .RIW(RIW), .SW(SW), .SEG_ID(g)
    ) seg_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .fill_i(fill && (seg_q == SW'(g))), .fill_tag_i(tag_q), .fill_line_i(arr_line),
      .wr_en_i(post_v), .wr_seg_i(post_row[RAW-1 -: SW]), .wr_tag_i(post_row[RIW-1:0]),
      .wr_col_i(post_col), .wr_data_i(post_data),
      .valid_o(seg_valid[g]), .tag_o(seg_tag[g]), .line_o(seg_line[g])
    );
  end

  cdram_refresh #(.RAW(RAW), .PERIOD(REF_PERIOD)) refresh_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .block_i(fill || post_v),
    .refresh_o(refresh_o), .row_o(refresh_row_o)
  );
endmodule

// File: rtl/cdram_cache_chk.sv
module cdram_cache_chk #(
  parameter int RAW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic           ready_o,
  input logic           rvalid_o,
  input logic           hit_no,
  input logic           refresh_o,
  input logic [RAW-1:0] refresh_row_o,
  input logic           fill_i,
  input logic           drain_i
);
  // R2
  rvalid_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ready_o);
  // R2
  rvalid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  // R4
  hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o) |=> $stable(hit_no));
  // R7
  write_noblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i) |=> ready_o);
  // R9
  refresh_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> (refresh_row_o == RAW'($past(refresh_row_o) + 1'b1)));
  // R10
  refresh_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> !fill_i);
  // R10
  refresh_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> !drain_i);
  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> !drain_i);
endmodule

bind cdram_cache cdram_cache_chk #(.RAW(RAW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .ready_o(ready_o), .rvalid_o(rvalid_o), .hit_no(hit_no),
  .refresh_o(refresh_o), .refresh_row_o(refresh_row_o),
  .fill_i(fill), .drain_i(post_v)
);

// File: tb/cdram_cache_tb_top.sv
`timescale 1ns/1ps
module cdram_cache_tb_top;
  localparam int DW = 16, NSEG = 4, RPS = 4, COLS = 8;
  localparam int HL = 2, ML = 5, RP = 16;
  localparam int RAW = 4, CAW = 3, NROWS = 16;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           req_i = 1'b0, we_i = 1'b0;
  logic [RAW-1:0] row_i = '0;
  logic [CAW-1:0] col_i = '0;
  logic [DW-1:0]  wdata_i = '0;
  logic           ready_o, rvalid_o, hit_no, refresh_o;
  logic [DW-1:0]  rdata_o;
  logic [RAW-1:0] refresh_row_o;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [NROWS][COLS];
  bit            lr_v [NSEG];
  int            lr_tag [NSEG];

  always #10 clk = ~clk;

  cdram_cache #(
    .DW(DW), .NSEG(NSEG), .ROWS_PER_SEG(RPS), .COLS(COLS),
    .HIT_LAT(HL), .MISS_LAT(ML), .REF_PERIOD(RP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .row_i(row_i),
    .col_i(col_i), .wdata_i(wdata_i), .ready_o(ready_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o), .hit_no(hit_no), .refresh_o(refresh_o),
    .refresh_row_o(refresh_row_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready_o && n < 50) begin @(negedge clk); n++; end
  endtask

  // read, optionally poking a write while busy (R11)
  task automatic rd(input int row, input int col, input bit poke = 0,
                    input int prow = 0, input int pcol = 0);
    int seg = row / RPS, tag = row % RPS, n;
    bit eh;
    wait_ready();
    eh = lr_v[seg] && (lr_tag[seg] == tag);
    req_i = 1; we_i = 0; row_i = RAW'(row); col_i = CAW'(col);
    @(negedge clk);
    n = 0;
    if (poke) begin
      we_i = 1; row_i = RAW'(prow); col_i = CAW'(pcol); wdata_i = 16'hDEAD;
    end else req_i = 0;
    chk(hit_no == !eh, "R4 read hit flag", hit_no, !eh);
    chk(ready_o == 0, "R2 busy after accept", ready_o, 0);
    if (poke) begin
      @(negedge clk); n++;
      req_i = 0; we_i = 0;
      chk(hit_no == !eh, "R11 flag untouched by ignored request", hit_no, !eh);
    end
    while (!rvalid_o && n < 20) begin @(negedge clk); n++; end
    if (eh) chk(n == HL, "R2 hit latency", n, HL);
    else    chk(n == ML, "R3 miss latency", n, ML);
    chk(rdata_o == ref_mem[row][col], "R5 read data", rdata_o, ref_mem[row][col]);
    chk(ready_o == 1, "R2 ready with rvalid", ready_o, 1);
    lr_v[seg] = 1; lr_tag[seg] = tag;
  endtask

  task automatic wr(input int row, input int col, input logic [DW-1:0] d);
    int seg = row / RPS, tag = row % RPS;
    bit eh;
    wait_ready();
    eh = lr_v[seg] && (lr_tag[seg] == tag);
    req_i = 1; we_i = 1; row_i = RAW'(row); col_i = CAW'(col); wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
    chk(ready_o == 1, "R7 write does not stall", ready_o, 1);
    chk(hit_no == !eh, "R4 write hit flag", hit_no, !eh);
    ref_mem[row][col] = d;
  endtask

  task automatic t_reset();
    chk(ready_o == 1, "R1 reset ready", ready_o, 1);
    chk(rvalid_o == 0, "R1 reset rvalid", rvalid_o, 0);
    chk(hit_no == 1, "R1 reset hit flag", hit_no, 1);
    chk(rdata_o == 0, "R1 reset rdata", rdata_o, 0);
    rd(0, 0);  // R1 cold miss returns zero
  endtask

  task automatic t_fill_all();
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < COLS; c++)
        wr(r, c, DW'(16'hA000 ^ (r << 4) ^ c));  // R8 row 0 cached: coherent
    rd(0, 3); rd(0, 7); rd(0, 1);              // R8 R5 hits after coherence
  endtask

  task automatic t_segments();
    rd(5, 2); rd(10, 4); rd(15, 6);           // R6 one miss per segment
    rd(0, 2); rd(5, 4); rd(10, 0); rd(15, 7); // R6 all still resident
    rd(1, 0); rd(1, 5); rd(0, 0);             // R5 eviction then reload
  endtask

  task automatic t_posted();
    wr(10, 6, 16'h1234); rd(10, 6);           // R7 back-to-back
    wr(2, 1, 16'h5678); rd(2, 1);             // R8 uncached row via miss
    wr(2, 1, 16'h9ABC); rd(2, 1);             // R8 cached row
  endtask

  task automatic t_ignore();
    rd(15, 0, 1, 3, 3);
    rd(3, 3);                                 // R11 poked word unchanged
  endtask

  task automatic t_refresh();
    int n = 0, cnt = 0;
    logic [RAW-1:0] r0;
    while (!refresh_o && n < 3 * RP) begin @(negedge clk); n++; end
    chk(refresh_o == 1, "R9 refresh pulse seen", refresh_o, 1);
    r0 = refresh_row_o;
    repeat (4 * RP) begin @(negedge clk); if (refresh_o) cnt++; end
    chk(cnt == 4, "R9 refresh rate", cnt, 4);
    chk(refresh_row_o == RAW'(r0 + 4), "R9 refresh row advance", refresh_row_o, RAW'(r0 + 4));
  endtask

  task automatic t_stress();
    int s = 7;
    for (int i = 0; i < 200; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      if (s[3]) wr((s >> 8) % NROWS, (s >> 16) % COLS, DW'(s >> 4));
      else      rd((s >> 8) % NROWS, (s >> 16) % COLS);  // R10 data intact
    end
  endtask

  initial begin
    for (int r = 0; r < NROWS; r++) for (int c = 0; c < COLS; c++) ref_mem[r][c] = '0;
    for (int g = 0; g < NSEG; g++) begin lr_v[g] = 0; lr_tag[g] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_fill_all();
    t_segments();
    t_posted();
    t_ignore();
    t_refresh();
    rd(5, 4); rd(12, 7);                      // R10 after idle refresh
    t_stress();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule